// File: doc/BRIEF.md
# Two-Source Vector Swizzle Interleaver

This unit assembles a destination vector of short subvectors by choosing each destination lane from one of two source vectors. The work is split into VL outer elements. Each element has its own selector word, which holds a 3-bit field for every destination lane. In each field, the high bit picks the source and the two low bits pick a lane inside that source's current subvector. The mapping is fully general, so it covers shuffle-style merges. One example is the pair of interleave passes that transpose a 4x4 matrix.

After a `start` pulse the unit latches the vector length and the two subvector sizes. It then processes one destination lane per clock, writing each result into a registered destination array. It raises `done` when the run finishes. A malformed selector or an out-of-range configuration stops the run early, and the unit then holds `illegal` and `done` together. The source arrays and the selector array are read live on every cycle, so they must stay steady until `done` rises.

Top module: `swz2_unit`

## Requirements
- R1: After reset, `done` and `illegal` are 0 and every element of `dst_arr` is 0.
- R2: For outer element v and destination lane i, the field is `sel_arr` bits [12v+3i+2 : 12v+3i]. Its result lands in `dst_arr` element v*DSUB+i, where element n occupies bits [8n+7:8n]. Positions that are not written keep their previous value.
- R3: A field whose bit 2 is 1 takes its value from `src_a`. A field whose bit 2 is 0 takes its value from `src_b`.
- R4: The source element index is v*SSUB plus field bits [1:0], in the chosen source. Element n of a source occupies bits [8n+7:8n].
- R5: If any selector bit of element v at position 3*DSUB or above is 1, the unit traps when it reaches lane 0 of that element. None of that element's lanes are written, and the unit stops with `illegal`=1 and `done`=1.
- R6: If field bits [1:0] are greater than or equal to SSUB, the unit traps on that lane. The lane is not written, lanes written earlier keep their values, and the unit stops with `illegal`=1 and `done`=1.
- R7: A start with DSUB or SSUB equal to 0 or above 4, or with VL above MAX_VL, writes nothing. It sets `illegal` and `done` on the start edge itself.
- R8: The unit processes exactly one lane per clock. `done` is 1 after edge k+L, where k is the accepted start edge and L is the number of lanes visited, counting a trapping lane. A start with VL=0 gives L=0 and `illegal`=0.
- R9: `done` and `illegal` hold until the next accepted start. A start that arrives while the unit is running, including on the edge that retires the last lane, is ignored.
- R10: With VL=1 and SSUB=DSUB=4, eight operations in two passes transpose a 4x4 matrix held as four rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| vl | input | $clog2(MAX_VL+1) | Number of outer elements |
| dst_subvl | input | 3 | Destination lanes per element (DSUB) |
| src_subvl | input | 3 | Source lanes per element (SSUB) |
| src_a | input | MAX_VL*4*ELEM_W | First source array, chosen when field bit 2 is 1 |
| src_b | input | MAX_VL*4*ELEM_W | Second source array, chosen when field bit 2 is 0 |
| sel_arr | input | MAX_VL*12 | One 12-bit selector word per outer element |
| dst_arr | output | MAX_VL*4*ELEM_W | Registered destination array |
| illegal | output | 1 | Trap flag, held with done |
| done | output | 1 | Operation finished, held until the next start |

## Verification
One collision matters here. A new `start` can arrive on the same clock edge that retires the final lane, which is the edge where `done` is being set. The bench provokes this by raising `start` with a corrupted configuration on exactly that edge. It expects the retirement to win: `done` stays high a few cycles later, and the destination array and measured latency still match the first operation. A similar poke in the middle of a run must change neither the result nor the lane count.

// File: rtl/swz2_pkg.sv
package swz2_pkg;
  localparam int MAX_LANES = 4;
  localparam int FLD_W     = 3;
  localparam int LANE_W    = 2;
  localparam int SUBVL_W   = 3;
  localparam int SEL_W     = MAX_LANES * FLD_W;

  typedef enum logic [0:0] {ST_IDLE, ST_RUN} swz_state_e;

  function automatic logic subvl_legal(input logic [SUBVL_W-1:0] s);
    return (s != '0) && (s <= SUBVL_W'(MAX_LANES));
  endfunction
endpackage

// File: rtl/swz2_pick.sv
module swz2_pick
  import swz2_pkg::*;
#(
  parameter int ELEM_W = 8,
  parameter int MAX_VL = 4,
  localparam int NELEM  = MAX_VL * MAX_LANES,
  localparam int IDX_W  = $clog2(NELEM),
  localparam int VIDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
)(
  input  logic [NELEM*ELEM_W-1:0] src_a,
  input  logic [NELEM*ELEM_W-1:0] src_b,
  input  logic [SEL_W-1:0]        sel_word,
  input  logic [VIDX_W-1:0]       vidx,
  input  logic [LANE_W-1:0]       lane,
  input  logic [SUBVL_W-1:0]      dsub,
  input  logic [SUBVL_W-1:0]      ssub,
  output logic [ELEM_W-1:0]       elem,
  output logic [IDX_W-1:0]        dst_idx,
  output logic                    trap
);
  logic [FLD_W-1:0]  fld;
  logic [1:0]        lo;
  logic              hi_bad;
  logic              lane_bad;
  logic [ELEM_W-1:0] a_e;
  logic [ELEM_W-1:0] b_e;
  int                sidx;

  always_comb begin
    fld    = sel_word[int'(lane)*FLD_W +: FLD_W];
    lo     = fld[1:0];
    // stray selector bits beyond the active destination lanes
    hi_bad = 1'b0;
    for (int b = 0; b < SEL_W; b++) begin
      if ((b >= FLD_W*int'(dsub)) && sel_word[b]) hi_bad = 1'b1;
    end
    lane_bad = ({1'b0, lo} >= ssub);
    sidx     = int'(vidx) * int'(ssub) + int'(lo);
    if (sidx > NELEM-1) sidx = NELEM-1;
    a_e      = src_a[sidx*ELEM_W +: ELEM_W];
    b_e      = src_b[sidx*ELEM_W +: ELEM_W];
    elem     = fld[2] ? a_e : b_e;
    dst_idx  = IDX_W'(int'(vidx) * int'(dsub) + int'(lane));
    trap     = hi_bad | lane_bad;
  end
endmodule

// File: rtl/swz2_seq.sv
module swz2_seq
  import swz2_pkg::*;
#(
  parameter int MAX_VL = 4,
  localparam int VL_W   = $clog2(MAX_VL+1),
  localparam int VIDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [VL_W-1:0]     vl,
  input  logic [SUBVL_W-1:0]  dsub_in,
  input  logic [SUBVL_W-1:0]  ssub_in,
  input  logic                lane_trap,
  output logic                busy,
  output logic                wr_en,
  output logic [VIDX_W-1:0]   vidx,
  output logic [LANE_W-1:0]   lane,
  output logic [SUBVL_W-1:0]  dsub_q,
  output logic [SUBVL_W-1:0]  ssub_q,
  output logic                done,
  output logic                illegal
);
  swz_state_e       state;
  logic [VL_W-1:0]  vl_q;
  logic             cfg_ok;
  logic             last_lane;
  logic             last_elem;

  assign cfg_ok    = subvl_legal(dsub_in) && subvl_legal(ssub_in) &&
                     (int'(vl) <= MAX_VL);
  assign last_lane = ({1'b0, lane} == dsub_q - SUBVL_W'(1));
  assign last_elem = (VL_W'(vidx) == vl_q - VL_W'(1));
  assign busy      = (state == ST_RUN);
  assign wr_en     = busy && !lane_trap;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      vl_q    <= '0;
      dsub_q  <= SUBVL_W'(1);
      ssub_q  <= SUBVL_W'(1);
      vidx    <= '0;
      lane    <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            vidx <= '0;
            lane <= '0;
            if (!cfg_ok) begin
              done    <= 1'b1;
              illegal <= 1'b1;
            end else if (vl == '0) begin
              done    <= 1'b1;
              illegal <= 1'b0;
            end else begin
              done    <= 1'b0;
              illegal <= 1'b0;
              vl_q    <= vl;
              dsub_q  <= dsub_in;
              ssub_q  <= ssub_in;
              state   <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (lane_trap) begin
            done    <= 1'b1;
            illegal <= 1'b1;
            state   <= ST_IDLE;
          end else if (last_lane) begin
            lane <= '0;
            if (last_elem) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              vidx <= vidx + VIDX_W'(1);
            end
          end else begin
            lane <= lane + LANE_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swz2_dst_ram.sv
module swz2_dst_ram #(
  parameter int ELEM_W = 8,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
)(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [IDX_W-1:0]        waddr,
  input  logic [ELEM_W-1:0]       wdata,
  output logic [DEPTH*ELEM_W-1:0] rd_flat
);
  logic [ELEM_W-1:0] mem [DEPTH];

  // single write port; every entry is visible so the array maps to registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign rd_flat[g*ELEM_W +: ELEM_W] = mem[g];
  end
endmodule

// File: rtl/swz2_unit.sv
module swz2_unit
  import swz2_pkg::*;
#(
  parameter int ELEM_W = 8,
  parameter int MAX_VL = 4
)(
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                start,
  input  logic [$clog2(MAX_VL+1)-1:0]         vl,
  input  logic [SUBVL_W-1:0]                  dst_subvl,
  input  logic [SUBVL_W-1:0]                  src_subvl,
  input  logic [MAX_VL*MAX_LANES*ELEM_W-1:0]  src_a,
  input  logic [MAX_VL*MAX_LANES*ELEM_W-1:0]  src_b,
  input  logic [MAX_VL*SEL_W-1:0]             sel_arr,
  output logic [MAX_VL*MAX_LANES*ELEM_W-1:0]  dst_arr,
  output logic                                illegal,
  output logic                                done
);
  localparam int NELEM  = MAX_VL * MAX_LANES;
  localparam int IDX_W  = $clog2(NELEM);
  localparam int VIDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;

  logic               busy;
  logic               wr_en;
  logic               trap;
  logic [VIDX_W-1:0]  vidx;
  logic [LANE_W-1:0]  lane;
  logic [SUBVL_W-1:0] dsub_q;
  logic [SUBVL_W-1:0] ssub_q;
  logic [SEL_W-1:0]   sel_word;
  logic [ELEM_W-1:0]  elem;
  logic [IDX_W-1:0]   dst_idx;
  logic               lane_trap;

  assign sel_word  = sel_arr[int'(vidx)*SEL_W +: SEL_W];
  assign lane_trap = busy && trap;

  swz2_seq #(.MAX_VL(MAX_VL)) seq_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .vl       (vl),
    .dsub_in  (dst_subvl),
    .ssub_in  (src_subvl),
    .lane_trap(lane_trap),
    .busy     (busy),
    .wr_en    (wr_en),
    .vidx     (vidx),
    .lane     (lane),
    .dsub_q   (dsub_q),
    .ssub_q   (ssub_q),
    .done     (done),
    .illegal  (illegal)
  );

  swz2_pick #(.ELEM_W(ELEM_W), .MAX_VL(MAX_VL)) pick_i (
    .src_a   (src_a),
    .src_b   (src_b),
    .sel_word(sel_word),
    .vidx    (vidx),
    .lane    (lane),
    .dsub    (dsub_q),
    .ssub    (ssub_q),
    .elem    (elem),
    .dst_idx (dst_idx),
    .trap    (trap)
  );

  swz2_dst_ram #(.ELEM_W(ELEM_W), .DEPTH(NELEM)) ram_i (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_en),
    .waddr  (dst_idx),
    .wdata  (elem),
    .rd_flat(dst_arr)
  );
endmodule

// File: rtl/swz2_chk.sv
module swz2_chk #(
  parameter int DW = 128
)(
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          done,
  input logic          illegal,
  input logic          busy,
  input logic          wr_en,
  input logic [DW-1:0] dst_arr
);
  // R5
  illegal_has_done_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> done);

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R9
  illegal_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(illegal) |-> $past(start));

  // R8
  run_not_done_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  // R8
  done_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(busy) || $past(start)));

  // R2
  dst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(dst_arr));
endmodule

bind swz2_unit swz2_chk #(.DW(MAX_VL*4*ELEM_W)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .done   (done),
  .illegal(illegal),
  .busy   (busy),
  .wr_en  (wr_en),
  .dst_arr(dst_arr)
);

// File: tb/swz2_unit_tb.sv
module swz2_unit_tb_top;
  localparam int EW  = 8;
  localparam int MVL = 4;
  localparam int NE  = MVL * 4;
  localparam int DW  = NE * EW;
  localparam int SW  = MVL * 12;
  localparam int VLW = $clog2(MVL+1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [VLW-1:0] vl_i = '0;
  logic [2:0]    dsv_i = 3'd1;
  logic [2:0]    ssv_i = 3'd1;
  logic [DW-1:0] src_a_i = '0;
  logic [DW-1:0] src_b_i = '0;
  logic [SW-1:0] sel_i = '0;
  logic [DW-1:0] dst_o;
  logic          ill_o;
  logic          done_o;

  always #4 clk = ~clk;

  swz2_unit #(.ELEM_W(EW), .MAX_VL(MVL)) dut_i (
    .clk(clk), .rst(rst), .start(start), .vl(vl_i),
    .dst_subvl(dsv_i), .src_subvl(ssv_i),
    .src_a(src_a_i), .src_b(src_b_i), .sel_arr(sel_i),
    .dst_arr(dst_o), .illegal(ill_o), .done(done_o)
  );

  typedef struct {
    logic [DW-1:0] mem;
    logic          ill;
    int            lat;
    string         req;
  } exp_t;

  exp_t          sb_q[$];
  logic [DW-1:0] model = '0;
  int            checks = 0;
  int            errors = 0;
  int            cyc = 0;
  int            st_cyc = 0;
  bit            armed = 1'b0;
  bit            finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] mk_sel(input int f0, input int f1,
                                         input int f2, input int f3);
    return {3'(f3), 3'(f2), 3'(f1), 3'(f0)};
  endfunction

  // monitor: pops the expected item when the run reports done
  always @(negedge clk) begin
    if (armed && done_o) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(dst_o == e.mem, e.req, "dst", dst_o, e.mem);
      chk(ill_o == e.ill, e.req, "illegal", DW'(ill_o), DW'(e.ill));
      chk((cyc - st_cyc) == e.lat, e.req, "latency", DW'(cyc - st_cyc), DW'(e.lat));
      armed = 1'b0;
    end
  end

  task automatic run_op(input int v, input int d, input int s,
                        input logic [SW-1:0] sels, input int poke,
                        input string req);
    exp_t e;
    bit   stop;
    int   word, f, lo, sidx;
    logic [2:0] keep;
    e.ill = 1'b0;
    e.lat = 0;
    stop  = 1'b0;
    if (d < 1 || d > 4 || s < 1 || s > 4 || v > MVL) begin
      e.ill = 1'b1;
    end else begin
      for (int vi = 0; vi < v && !stop; vi++) begin
        word = int'(sels[vi*12 +: 12]);
        for (int i = 0; i < d && !stop; i++) begin
          e.lat++;
          f  = (word >> (3*i)) & 7;
          lo = f & 3;
          if ((word >> (3*d)) != 0 || lo >= s) begin
            e.ill = 1'b1;
            stop  = 1'b1;
          end else begin
            sidx = vi*s + lo;
            model[(vi*d+i)*EW +: EW] = (f & 4) != 0 ? src_a_i[sidx*EW +: EW]
                                                    : src_b_i[sidx*EW +: EW];
          end
        end
      end
    end
    e.mem = model;
    e.req = req;
    sb_q.push_back(e);
    @(negedge clk);
    vl_i  = VLW'(v);
    dsv_i = 3'(d);
    ssv_i = 3'(s);
    sel_i = sels;
    start = 1'b1;
    @(posedge clk);
    #1;
    start  = 1'b0;
    st_cyc = cyc;
    armed  = 1'b1;
    if (poke > 0) begin
      keep = dsv_i;
      repeat (poke-1) @(posedge clk);
      @(negedge clk);
      start = 1'b1;
      dsv_i = 3'd0;
      vl_i  = '0;
      @(posedge clk);
      #1;
      start = 1'b0;
      dsv_i = keep;
    end
    wait (!armed);
    if (poke > 0) begin
      repeat (2) @(negedge clk);
      // R9 start during the run left the result and done in place
      chk(done_o == 1'b1, "R9", "done held", DW'(done_o), DW'(1));
      chk(dst_o == model, "R9", "dst kept", dst_o, model);
    end
  endtask

  task automatic swz_row(input logic [31:0] ra, input logic [31:0] rb,
                         input logic [11:0] sel, output logic [31:0] res);
    src_a_i = DW'(ra);
    src_b_i = DW'(rb);
    run_op(1, 4, 4, SW'(sel), 0, "R10");
    res = dst_o[31:0];
  endtask

  initial begin
    logic [31:0] in_r [4];
    logic [31:0] t_r  [4];
    logic [31:0] o_r  [4];
    logic [31:0] want;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(done_o == 1'b0, "R1", "done", DW'(done_o), '0);
    chk(ill_o == 1'b0, "R1", "illegal", DW'(ill_o), '0);
    chk(dst_o == '0, "R1", "dst", dst_o, '0);

    for (int n = 0; n < NE; n++) begin
      src_a_i[n*EW +: EW] = EW'(8'hA0 + n);
      src_b_i[n*EW +: EW] = EW'(8'hB0 + n);
    end
    // R2 R3: full-width reverse pick from the first source
    run_op(4, 4, 4, {4{mk_sel(7, 6, 5, 4)}}, 0, "R2");
    // R4: mixed sources with SSUB=2, DSUB=3
    run_op(3, 3, 2, {12'h0, {3{mk_sel(1, 4, 5, 0)}}}, 0, "R4");
    // R3 R9: second source heavy, start poked mid-run
    run_op(4, 2, 4, {4{mk_sel(3, 6, 0, 0)}}, 3, "R3");
    // R5: stray bit above the active lanes in element 1
    run_op(2, 3, 4, {24'h0, mk_sel(2, 2, 2, 1), mk_sel(4, 0, 1, 0)}, 0, "R5");
    // R6: lane index 2 with SSUB=2 in element 1 lane 1
    run_op(2, 4, 2, {24'h0, mk_sel(1, 6, 0, 0), mk_sel(0, 5, 1, 4)}, 0, "R6");
    // R7: illegal configurations
    run_op(1, 0, 4, SW'(mk_sel(4, 4, 4, 4)), 0, "R7");
    run_op(1, 4, 5, SW'(mk_sel(4, 4, 4, 4)), 0, "R7");
    run_op(5, 4, 4, SW'(mk_sel(4, 4, 4, 4)), 0, "R7");
    // R8: empty vector
    run_op(0, 2, 2, '0, 0, "R8");
    // R8 R9: start on the edge retiring the last lane
    run_op(1, 2, 3, SW'(mk_sel(6, 1, 0, 0)), 2, "R8");

    // R10: two-pass 4x4 transpose; row k lane j holds {j,k}
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 4; j++) in_r[k][j*8 +: 8] = 8'((j << 4) | k);
    swz_row(in_r[0], in_r[1], mk_sel(4, 0, 6, 2), t_r[0]);
    swz_row(in_r[0], in_r[1], mk_sel(5, 1, 7, 3), t_r[1]);
    swz_row(in_r[2], in_r[3], mk_sel(4, 0, 6, 2), t_r[2]);
    swz_row(in_r[2], in_r[3], mk_sel(5, 1, 7, 3), t_r[3]);
    swz_row(t_r[0], t_r[2], mk_sel(4, 5, 0, 1), o_r[0]);
    swz_row(t_r[1], t_r[3], mk_sel(4, 5, 0, 1), o_r[1]);
    swz_row(t_r[0], t_r[2], mk_sel(6, 7, 2, 3), o_r[2]);
    swz_row(t_r[1], t_r[3], mk_sel(6, 7, 2, 3), o_r[3]);
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) want[c*8 +: 8] = 8'((r << 4) | c);
      chk(o_r[r] == want, "R10", "transposed row", DW'(o_r[r]), DW'(want));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual no done expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule